// File: doc/BRIEF.md
# Multi-Mode Serial Result Port

This block holds one 16-bit conversion result and sends it out on a single serial data line. A static two-bit format select picks one of three formats. The first is an asynchronous format, where the word goes out as two framed bytes. The second is a raw synchronous format timed by a serial clock supplied from outside. The third is a raw synchronous format where the block makes its own serial clock, running at a quarter of the master clock. A new result is written in with a one-cycle load strobe. An active-low ready flag tells the host that a word is waiting. The host starts a transfer by pulling the active-low select low.

All logic runs on the master clock. An external serial clock first passes through a two-flop synchronizer. The block then acts on its rising and falling edges: a rising edge marks the sample point, and the data line moves on after the following falling edge. In self-clocked mode a phase counter makes the same pair of events and also drives them out as the generated clock. The held word and the word in flight are separate registers. A load that arrives during a transfer therefore waits for the next select cycle and does not corrupt the bits going out.

Top module: `serial_result_port`

## Requirements
- R1: Format select codes are 00 asynchronous, 01 external-clock synchronous, 10 self-clocked and 11 external-clock synchronous. The generated-clock enable output is high, one cycle after the select is sampled, only while the code is 10.
- R2: In asynchronous mode the word goes out as two 11-bit frames, the high byte first. Each frame is a 0 start bit, then the eight byte bits least significant first, then two 1 stop bits. Each bit is sampled on one rising serial-clock edge, 22 edges in all.
- R3: In either external-clock synchronous code the 16 bits go out unframed, most significant bit first, one bit per rising edge of the external serial clock. The line moves to the next bit only after a falling edge.
- R4: In self-clocked mode the generated clock is high for one master cycle in every four and gives 16 pulses per word. It stays low outside a transfer.
- R5: A transfer starts on the first master-clock edge at which select is low, the port is idle and ready is low. The first bit is on the data line before the first rising serial-clock edge.
- R6: Ready is high out of reset and stays high until the first load. It is low while a loaded word waits. It goes high once the last bit of the word has been sent, at the falling serial-clock edge after the final rising edge.
- R7: After a load, ready is high for exactly four master-clock cycles, starting with the cycle after the load edge. It is then low, whether or not a transfer is in progress.
- R8: If select rises before a word is complete, the transfer stops, the data line returns high and ready stays low. The next select cycle sends the whole word again from its first bit.
- R9: A load during a transfer leaves the bits going out unchanged. Ready is low after that transfer ends, and the next select cycle sends the newly loaded word.
- R10: The data-output enable is the inverse of select, delayed by one master-clock cycle. The data line is high whenever no bit is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle strobe that writes a new result |
| load_data_i | input | 16 | Result word captured on load |
| cs_n_i | input | 1 | Active-low select that starts and frames a transfer |
| mode_i | input | 2 | Static format select |
| sclk_i | input | 1 | External serial clock (asynchronous to clk) |
| sdata_o | output | 1 | Serial data line, idle high |
| sdata_oe_o | output | 1 | Drive enable for the serial data line |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe_o | output | 1 | Drive enable for the generated serial clock |
| rdy_n_o | output | 1 | Active-low word-ready flag |

## Verification
The assertions assume that the format select changes only while select is high and the port is idle, and that select is held high through reset. The bench writes the select code only between transfers, and it raises select only before reset ends or after a word has finished or been aborted. The external serial clock is assumed to hold each level for several master cycles so that the synchronizer sees every edge. The bench holds each level for six cycles and changes it on the falling master-clock edge. Loads are assumed to come at least four cycles apart whenever the blanking window itself is being checked.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    FMT_ASYNC   = 2'b00,
    FMT_EXTCLK  = 2'b01,
    FMT_SELFCLK = 2'b10,
    FMT_EXTALT  = 2'b11
  } srp_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DONE  = 2'b10
  } srp_state_e;
endpackage

// File: rtl/srp_framer.sv
module srp_framer #(
  parameter int DATA_W    = 16,
  parameter int STOP_BITS = 2,
  localparam int NBYTES   = DATA_W / 8,
  localparam int FRAME_W  = 9 + STOP_BITS,
  localparam int SEQ_W    = (NBYTES * FRAME_W > DATA_W) ? NBYTES * FRAME_W : DATA_W,
  localparam int CNT_W    = $clog2(SEQ_W + 1)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        mode_i,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [CNT_W-1:0]  len_o
);
  import srp_pkg::*;

  logic [SEQ_W-1:0] async_seq;
  logic [SEQ_W-1:0] sync_seq;

  // Byte frames: start 0, data LSB first, stop ones; high byte leaves first.
  always_comb begin
    async_seq = '1;
    for (int b = 0; b < NBYTES; b++) begin
      async_seq[b*FRAME_W] = 1'b0;
      for (int k = 0; k < 8; k++) begin
        async_seq[b*FRAME_W + 1 + k] = word_i[DATA_W - 8 - 8*b + k];
      end
    end
  end

  // Raw word, MSB in bit 0 so it is emitted first.
  always_comb begin
    sync_seq = '1;
    for (int i = 0; i < DATA_W; i++) begin
      sync_seq[i] = word_i[DATA_W-1-i];
    end
  end

  always_comb begin
    if (mode_i == FMT_ASYNC) begin
      seq_o = async_seq;
      len_o = CNT_W'(NBYTES * FRAME_W);
    end else begin
      seq_o = sync_seq;
      len_o = CNT_W'(DATA_W);
    end
  end
endmodule

// File: rtl/srp_clk_unit.sv
module srp_clk_unit #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV         = 4,
  localparam int PH_W       = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       cs_n_i,
  input  logic       active_i,
  input  logic       sclk_i,
  output logic       rise_o,
  output logic       fall_o,
  output logic       sclk_o,
  output logic       sclk_oe_o
);
  import srp_pkg::*;

  logic [SYNC_STAGES:0] sync_q;
  logic [PH_W-1:0]      phase_q;
  logic                 sclk_q;
  logic                 sclk_oe_q;
  logic                 self_mode;
  logic                 gen_run;
  logic                 gen_rise;
  logic                 gen_fall;
  logic                 ext_rise;
  logic                 ext_fall;

  assign self_mode = (mode_i == FMT_SELFCLK);
  assign gen_run   = active_i & ~cs_n_i & self_mode;

  // Synchronizer chain plus one history flop for edge detection.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_i};
  end

  assign ext_rise =  sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_fall = ~sync_q[SYNC_STAGES-1] &  sync_q[SYNC_STAGES];

  // Phase 1 is the parking value so the first rise comes DIV-1 cycles in.
  always_ff @(posedge clk) begin
    if (rst || !gen_run)                 phase_q <= PH_W'(1);
    else if (phase_q == PH_W'(DIV - 1))  phase_q <= '0;
    else                                 phase_q <= phase_q + PH_W'(1);
  end

  assign gen_rise = gen_run && (phase_q == PH_W'(DIV - 1));
  assign gen_fall = gen_run && (phase_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      sclk_oe_q <= 1'b0;
    end else begin
      sclk_q    <= gen_rise;
      sclk_oe_q <= self_mode;
    end
  end

  assign rise_o    = self_mode ? gen_rise : ext_rise;
  assign fall_o    = self_mode ? gen_fall : ext_fall;
  assign sclk_o    = sclk_q;
  assign sclk_oe_o = sclk_oe_q;
endmodule

// File: rtl/srp_ready.sv
module srp_ready #(
  parameter int BLANK_CYC = 4,
  localparam int BW       = $clog2(BLANK_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic done_i,
  output logic rdy_n_o
);
  logic [BW-1:0] blank_q, blank_d;
  logic          valid_q, valid_d;
  logic          taken_q, taken_d;
  logic          rdy_n_q;

  always_comb begin
    blank_d = (blank_q != '0) ? blank_q - BW'(1) : '0;
    valid_d = valid_q;
    taken_d = taken_q;
    if (start_i) taken_d = 1'b1;
    if (abort_i) taken_d = 1'b0;
    if (done_i && taken_q) begin
      valid_d = 1'b0;
      taken_d = 1'b0;
    end
    // A new word overrides any retirement of the one in flight.
    if (load_i) begin
      blank_d = BW'(BLANK_CYC);
      valid_d = 1'b1;
      taken_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q <= '0;
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      rdy_n_q <= 1'b1;
    end else begin
      blank_q <= blank_d;
      valid_q <= valid_d;
      taken_q <= taken_d;
      rdy_n_q <= (blank_d != '0) | ~valid_d;
    end
  end

  assign rdy_n_o = rdy_n_q;
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
  parameter int SEQ_W = 22,
  localparam int CNT_W = $clog2(SEQ_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_i,
  input  logic             rdy_n_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             active_o,
  output logic             start_o,
  output logic             abort_o,
  output logic             done_o,
  output logic             sdata_o,
  output logic             sdata_oe_o
);
  import srp_pkg::*;

  srp_state_e       state_q;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hi_seen_q;
  logic             sdata_q;
  logic             oe_q;
  logic             last_bit;

  assign last_bit = (cnt_q == len_i);
  assign start_o  = (state_q == ST_IDLE) && !cs_n_i && !rdy_n_i;
  assign abort_o  = (state_q == ST_SHIFT) && cs_n_i;
  assign done_o   = (state_q == ST_SHIFT) && !cs_n_i && !rise_i && fall_i
                    && hi_seen_q && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      seq_q     <= '1;
      cnt_q     <= '0;
      hi_seen_q <= 1'b0;
      sdata_q   <= 1'b1;
      oe_q      <= 1'b0;
    end else begin
      oe_q <= ~cs_n_i;
      unique case (state_q)
        ST_IDLE: begin
          sdata_q <= 1'b1;
          if (start_o) begin
            state_q   <= ST_SHIFT;
            seq_q     <= seq_i;
            sdata_q   <= seq_i[0];
            cnt_q     <= '0;
            hi_seen_q <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (cs_n_i) begin
            state_q <= ST_IDLE;
            sdata_q <= 1'b1;
          end else if (rise_i) begin
            hi_seen_q <= 1'b1;
            cnt_q     <= cnt_q + CNT_W'(1);
          end else if (fall_i && hi_seen_q) begin
            hi_seen_q <= 1'b0;
            if (last_bit) begin
              state_q <= ST_DONE;
              sdata_q <= 1'b1;
            end else begin
              seq_q   <= {1'b1, seq_q[SEQ_W-1:1]};
              sdata_q <= seq_q[1];
            end
          end
        end
        ST_DONE: begin
          sdata_q <= 1'b1;
          if (cs_n_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o   = (state_q == ST_SHIFT);
  assign sdata_o    = sdata_q;
  assign sdata_oe_o = oe_q;
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int DATA_W      = 16,
  parameter int STOP_BITS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIV         = 4,
  parameter int BLANK_CYC   = 4,
  localparam int NBYTES     = DATA_W / 8,
  localparam int FRAME_W    = 9 + STOP_BITS,
  localparam int SEQ_W      = (NBYTES * FRAME_W > DATA_W) ? NBYTES * FRAME_W : DATA_W,
  localparam int CNT_W      = $clog2(SEQ_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              cs_n_i,
  input  logic [1:0]        mode_i,
  input  logic              sclk_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              rdy_n_o
);
  logic [DATA_W-1:0] hold_q;
  logic [SEQ_W-1:0]  seq;
  logic [CNT_W-1:0]  len;
  logic              rise, fall, active;
  logic              start, abort, done;

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (load_i) hold_q <= load_data_i;
  end

  srp_framer #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_framer (
    .word_i (hold_q),
    .mode_i (mode_i),
    .seq_o  (seq),
    .len_o  (len)
  );

  srp_clk_unit #(.SYNC_STAGES(SYNC_STAGES), .DIV(DIV)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .cs_n_i    (cs_n_i),
    .active_i  (active),
    .sclk_i    (sclk_i),
    .rise_o    (rise),
    .fall_o    (fall),
    .sclk_o    (sclk_o),
    .sclk_oe_o (sclk_oe_o)
  );

  srp_ready #(.BLANK_CYC(BLANK_CYC)) u_ready (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .start_i (start),
    .abort_i (abort),
    .done_i  (done),
    .rdy_n_o (rdy_n_o)
  );

  srp_shifter #(.SEQ_W(SEQ_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_n_i     (cs_n_i),
    .rdy_n_i    (rdy_n_o),
    .seq_i      (seq),
    .len_i      (len),
    .rise_i     (rise),
    .fall_i     (fall),
    .active_o   (active),
    .start_o    (start),
    .abort_o    (abort),
    .done_o     (done),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker (
  input logic       clk,
  input logic       rst,
  input logic       load_i,
  input logic       cs_n_i,
  input logic [1:0] mode_i,
  input logic       sdata_o,
  input logic       sdata_oe_o,
  input logic       sclk_o,
  input logic       sclk_oe_o,
  input logic       rdy_n_o
);
  AST_BLANK_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> rdy_n_o ##1 rdy_n_o ##1 rdy_n_o ##1 rdy_n_o); // R7

  AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
    !cs_n_i |=> sdata_oe_o); // R10

  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !sdata_oe_o); // R10

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> sdata_o); // R8

  AST_GEN_CLK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10) |=> sclk_oe_o); // R1

  AST_GEN_CLK_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b10) |=> !sclk_oe_o); // R1

  AST_GEN_CLK_DUTY: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |=> !sclk_o ##1 !sclk_o ##1 !sclk_o); // R4

  AST_GEN_CLK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe_o |-> !sclk_o); // R4
endmodule

bind serial_result_port srp_checker u_srp_checker (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .cs_n_i     (cs_n_i),
  .mode_i     (mode_i),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .sclk_o     (sclk_o),
  .sclk_oe_o  (sclk_oe_o),
  .rdy_n_o    (rdy_n_o)
);

// File: tb/tb_serial_result_port.sv
module tb_serial_result_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic        cs_n_i = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic        sclk_i = 1'b0;
  logic        sdata_o, sdata_oe_o, sclk_o, sclk_oe_o, rdy_n_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [21:0] cap;

  always #10 clk = ~clk;

  serial_result_port dut (
    .clk(clk), .rst(rst), .load_i(load_i), .load_data_i(load_data_i),
    .cs_n_i(cs_n_i), .mode_i(mode_i), .sclk_i(sclk_i), .sdata_o(sdata_o),
    .sdata_oe_o(sdata_oe_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .rdy_n_o(rdy_n_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int nbits(int md);
    return (md == 0) ? 22 : 16;
  endfunction

  // Expected i-th line bit, computed from the format rules.
  function automatic logic exp_bit(int md, logic [15:0] w, int i);
    logic [7:0] by;
    int p;
    if (md != 0) return w[15-i];
    by = (i < 11) ? w[15:8] : w[7:0];
    p = i % 11;
    if (p == 0) return 1'b0;
    if (p <= 8) return by[p-1];
    return 1'b1;
  endfunction

  function automatic logic [21:0] exp_seq(int md, logic [15:0] w);
    logic [21:0] s = '0;
    for (int i = 0; i < nbits(md); i++) s[i] = exp_bit(md, w, i);
    return s;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(logic [15:0] w, bit check_blank);
    @(negedge clk);
    load_i = 1'b1;
    load_data_i = w;
    @(negedge clk);
    load_i = 1'b0;
    if (check_blank) begin
      check("R7 blank c0", rdy_n_o, 1);
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        check("R7 blank", rdy_n_o, 1);
      end
      @(negedge clk);
      check("R7 ready after blank", rdy_n_o, 0);
    end else begin
      wait_cyc(5);
    end
  endtask

  // n external clock pulses, capturing before each rising edge.
  task automatic ext_bits(int n, int base);
    for (int i = 0; i < n; i++) begin
      cap[base+i] = sdata_o;
      sclk_i = 1'b1;
      wait_cyc(6);
      sclk_i = 1'b0;
      wait_cyc(6);
    end
  endtask

  task automatic ext_word(int md, logic [15:0] w);
    cap = '0;
    cs_n_i = 1'b0;
    wait_cyc(6);
    check("R10 oe on select", sdata_oe_o, 1);
    ext_bits(nbits(md), 0);
    check(md == 0 ? "R2 async frame" : "R3 sync word", cap, exp_seq(md, w));
    check("R6 ready high after word", rdy_n_o, 1);
    check("R10 line idle high", sdata_o, 1);
    cs_n_i = 1'b1;
    wait_cyc(2);
    check("R10 oe off", sdata_oe_o, 0);
  endtask

  task automatic self_word(logic [15:0] w);
    int n = 0, hi = 0, last = -1, t = 0;
    logic prev = 1'b0;
    cap = '0;
    cs_n_i = 1'b0;
    while (n < 16 && t < 400) begin
      @(negedge clk);
      t++;
      if (sclk_o) hi++;
      if (sclk_o && !prev) begin
        cap[n] = sdata_o;
        if (last >= 0) check("R4 period", t - last, 4);
        last = t;
        n++;
      end
      prev = sclk_o;
    end
    wait_cyc(8);
    check("R4 pulses", hi, 16);
    check("R4 clock low after", sclk_o, 0);
    check("R3 self word", cap, exp_seq(2, w));
    check("R6 ready high after word", rdy_n_o, 1);
    cs_n_i = 1'b1;
    wait_cyc(2);
  endtask

  logic [15:0] words [8] = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h5AA5,
                             16'h8001, 16'h1234, 16'h00FF, 16'hFF00};

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    check("R6 reset ready", rdy_n_o, 1);
    check("R10 reset oe", sdata_oe_o, 0);
    check("R10 reset line", sdata_o, 1);
    check("R4 reset sclk", sclk_o, 0);

    // R5: select low with nothing loaded starts nothing.
    cs_n_i = 1'b0;
    wait_cyc(6);
    sclk_i = 1'b1; wait_cyc(6); sclk_i = 1'b0; wait_cyc(6);
    check("R5 no start without word", sdata_o, 1);
    cs_n_i = 1'b1;
    wait_cyc(2);

    foreach (words[j]) begin
      mode_i = 2'b00; wait_cyc(2);
      check("R1 async gen off", sclk_oe_o, 0);
      do_load(words[j], 1'b1);
      ext_word(0, words[j]);
    end
    mode_i = 2'b01; wait_cyc(2);
    for (int b = 0; b < 16; b++) begin
      do_load(16'h0001 << b, 1'b1);
      ext_word(1, 16'h0001 << b);
    end
    foreach (words[j]) begin
      do_load(words[j], 1'b0);
      ext_word(1, words[j]);
    end
    mode_i = 2'b11; wait_cyc(2);
    check("R1 alt code gen off", sclk_oe_o, 0);
    do_load(16'hC3A1, 1'b1);
    ext_word(3, 16'hC3A1);
    mode_i = 2'b10; wait_cyc(2);
    check("R1 self gen on", sclk_oe_o, 1);
    foreach (words[j]) begin
      do_load(words[j], 1'b1);
      self_word(words[j]);
    end

    // R8: abort mid-word, then full resend.
    mode_i = 2'b01; wait_cyc(2);
    do_load(16'hBEEF, 1'b0);
    cs_n_i = 1'b0; wait_cyc(6);
    ext_bits(5, 0);
    cs_n_i = 1'b1; wait_cyc(2);
    check("R8 ready stays low", rdy_n_o, 0);
    check("R8 line high", sdata_o, 1);
    ext_word(1, 16'hBEEF);

    // R9: load during transfer.
    do_load(16'h1357, 1'b0);
    cs_n_i = 1'b0; wait_cyc(6);
    cap = '0;
    ext_bits(6, 0);
    do_load(16'h2468, 1'b1);
    ext_bits(10, 6);
    check("R9 word in flight intact", cap, exp_seq(1, 16'h1357));
    check("R9 new word pending", rdy_n_o, 0);
    cs_n_i = 1'b1; wait_cyc(2);
    ext_word(1, 16'h2468);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule